// File: doc/BRIEF.md
# Fault-Injectable Phase-Change Memory Array

This block is a small synthesizable word-addressed array that behaves like a phase-change cell array. It serves as a known-faulty device under test for memory self-test controllers. Each cell stores a logic value: 1 is the crystalline (set) state and 0 is the amorphous (reset) state. Each cell also carries a marginal flag. The flag marks a reset cell that has partly crystallised.

A normal read reports marginal cells as 0. A margin read uses a lower reference threshold and reports them as 1. A configuration input selects one fault type at a time and a victim word. For the thermal neighbour fault it also selects an aggressor word. The test logic can then check whether its algorithm detects each phase-change failure mechanism.

All words are `DATA_W` bits wide, and a fault acts on every bit of the victim word independently. Read data is registered. Write takes priority over read when both are requested in the same cycle. Configuration is meant to change only while the array is idle. The history bits of the stuck faults are cleared only by reset.

Top module: `pcm_fault_mem`

## Requirements
- R1: After reset every word reads 0 with both normal and margin reads, and `rdata_o` is 0.
- R2: With fault code 0, a read (`re_i`=1, `we_i`=0) returns the last word written to that address on `rdata_o` one cycle later, for both normal and margin reads. `rdata_o` holds its value in any cycle without a read. When `we_i` and `re_i` are both 1, only the write is performed.
- R3: Fault codes on `fault_sel_i` are: 0 none, 1 proximity disturb, 2 read recovery, 3 read disturb, 4 false write, 5 stuck set, 6 stuck reset, 7 incomplete program. Addresses other than the victim behave as in R2 under every code.
- R4: Proximity disturb (code 1) fires when the aggressor equals the victim plus or minus 1, with no wrap-around, and the aggressor is written. Each victim bit that holds 0 where the written bit is 0 becomes marginal. The victim's normal read value does not change, and a margin read shows those bits as 1. A non-neighbouring aggressor has no effect.
- R5: Read recovery (code 2): a write of the victim immediately followed by a read of the victim returns the new data OR'd with the bits that changed from 1 to 0. Any later read returns the written data, as does a read that is separated from the write by another operation.
- R6: Read disturb (code 3): a read of the victim returns its stored value. Afterwards every 0 bit of the victim is marginal, so a margin read returns all ones while a normal read still returns the stored value.
- R7: False write (code 4): a read of the victim returns its stored value and then clears the victim to 0.
- R8: Stuck set (code 5): each victim bit reads 1 permanently once a 0 has been written to it.
- R9: Stuck reset (code 6): each victim bit reads 0 permanently once a 0 has been written to it, and later writes of 1 to it have no effect. Bits not yet written 0 follow writes.
- R10: Incomplete program (code 7): every victim bit written 0 becomes marginal. A normal read returns the written data and a margin read returns all ones.
- R11: A normal write of a word clears its marginal flags, so a margin read afterwards returns the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Word address for read or write |
| we_i | input | 1 | Write enable |
| wdata_i | input | DATA_W | Write data |
| re_i | input | 1 | Read enable |
| margin_i | input | 1 | 1 selects the margin (low threshold) read |
| rdata_o | output | DATA_W | Registered read data |
| fault_sel_i | input | 3 | Active fault code |
| victim_i | input | ADDR_W | Victim word address |
| aggressor_i | input | ADDR_W | Aggressor word address for proximity disturb |

## Verification
Every word is read after reset with both thresholds. The fault-free array is then swept with an address-dependent pattern, which shows that distinct words do not alias and that simultaneous write and read favours the write.

Proximity disturb is swept over all 256 victim/aggressor data pairs, using both neighbours and non-neighbouring or wrapped aggressors. This separates the neighbour rule from the per-bit coupling rule. Read recovery is swept over all 256 old/new pairs, both with and without an intervening operation, which distinguishes the one-operation window from a sticky fault.

Read disturb, false write and incomplete program are tried with all 16 data values. The stuck faults are driven with a write sequence whose arming history is accumulated in the bench, which tells per-bit arming apart from word-wide arming. A non-victim word is exercised under every code.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_PROX    = 3'd1,
    FLT_RREC    = 3'd2,
    FLT_RDIST   = 3'd3,
    FLT_FWRITE  = 3'd4,
    FLT_STK_SET = 3'd5,
    FLT_STK_RST = 3'd6,
    FLT_INCPRG  = 3'd7
  } fault_e;
endpackage

// File: rtl/pcm_cell_array.sv
module pcm_cell_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_val_i,
  input  logic              vic_upd_i,
  input  logic [ADDR_W-1:0] vic_addr_i,
  input  logic [DATA_W-1:0] vic_nval_i,
  input  logic [DATA_W-1:0] vic_nmrg_i,
  output logic [DATA_W-1:0] rd_val_o,
  output logic [DATA_W-1:0] rd_mrg_o,
  output logic [DATA_W-1:0] vic_val_o,
  output logic [DATA_W-1:0] vic_mrg_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] val_w [DEPTH];
  logic [DATA_W-1:0] mrg_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : gen_word
    logic [DATA_W-1:0] val_q;
    logic [DATA_W-1:0] mrg_q;
    logic              vic_hit;
    logic              wr_hit;

    assign vic_hit = vic_upd_i && (vic_addr_i == ADDR_W'(i));
    assign wr_hit  = wr_en_i && (addr_i == ADDR_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q <= '0;
        mrg_q <= '0;
      end else if (vic_hit) begin
        val_q <= vic_nval_i;
        mrg_q <= vic_nmrg_i;
      end else if (wr_hit) begin
        val_q <= wr_val_i;
        mrg_q <= '0;
      end
    end

    assign val_w[i] = val_q;
    assign mrg_w[i] = mrg_q;
  end

  assign rd_val_o  = val_w[addr_i];
  assign rd_mrg_o  = mrg_w[addr_i];
  assign vic_val_o = val_w[vic_addr_i];
  assign vic_mrg_o = mrg_w[vic_addr_i];
endmodule

// File: rtl/pcm_fault_ctrl.sv
module pcm_fault_ctrl
  import pcm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        fault_sel_i,
  input  logic [ADDR_W-1:0] victim_i,
  input  logic [ADDR_W-1:0] aggressor_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_op_i,
  input  logic              rd_op_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] vic_val_i,
  input  logic [DATA_W-1:0] vic_mrg_i,
  output logic              vic_upd_o,
  output logic [DATA_W-1:0] vic_nval_o,
  output logic [DATA_W-1:0] vic_nmrg_o,
  output logic [DATA_W-1:0] rd_force_o,
  output logic [DATA_W-1:0] armed_o
);
  fault_e            fault;
  logic [ADDR_W:0]   vic_ext;
  logic [ADDR_W:0]   agg_ext;
  logic [ADDR_W:0]   one_ext;
  logic              adjacent;
  logic              vic_sel;
  logic              agg_wr;
  logic              stuck_mode;
  logic [DATA_W-1:0] armed_q;
  logic [DATA_W-1:0] armed_n;
  logic [DATA_W-1:0] pend_q;

  assign fault    = fault_e'(fault_sel_i);
  assign vic_ext  = {1'b0, victim_i};
  assign agg_ext  = {1'b0, aggressor_i};
  assign one_ext  = {{ADDR_W{1'b0}}, 1'b1};
  // neighbours in the linear array, no wrap
  assign adjacent = (vic_ext + one_ext == agg_ext) || (agg_ext + one_ext == vic_ext);
  assign vic_sel  = (addr_i == victim_i);
  assign agg_wr   = wr_op_i && (addr_i == aggressor_i) && adjacent;

  assign stuck_mode = (fault == FLT_STK_SET) || (fault == FLT_STK_RST);
  assign armed_n    = armed_q | ~wdata_i;

  always_comb begin
    vic_upd_o  = 1'b0;
    vic_nval_o = vic_val_i;
    vic_nmrg_o = vic_mrg_i;
    if (wr_op_i && vic_sel) begin
      vic_upd_o  = 1'b1;
      vic_nval_o = wdata_i;
      vic_nmrg_o = '0;
      unique case (fault)
        FLT_STK_SET: vic_nval_o = wdata_i | armed_n;
        FLT_STK_RST: vic_nval_o = wdata_i & ~armed_n;
        FLT_INCPRG:  vic_nmrg_o = ~wdata_i;
        default: ;
      endcase
    end else if (fault == FLT_PROX && agg_wr) begin
      vic_upd_o  = 1'b1;
      vic_nmrg_o = vic_mrg_i | (~vic_val_i & ~wdata_i);
    end else if (rd_op_i && vic_sel) begin
      if (fault == FLT_RDIST) begin
        vic_upd_o  = 1'b1;
        vic_nmrg_o = vic_mrg_i | ~vic_val_i;
      end else if (fault == FLT_FWRITE) begin
        vic_upd_o  = 1'b1;
        vic_nval_o = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= '0;
      pend_q  <= '0;
    end else begin
      if (wr_op_i && vic_sel && stuck_mode) armed_q <= armed_n;
      if (wr_op_i || rd_op_i) begin
        if (wr_op_i && vic_sel && fault == FLT_RREC) pend_q <= vic_val_i & ~wdata_i;
        else                                          pend_q <= '0;
      end
    end
  end

  assign rd_force_o = (rd_op_i && vic_sel) ? pend_q : '0;
  assign armed_o    = armed_q;
endmodule

// File: rtl/pcm_read_port.sv
module pcm_read_port #(
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_op_i,
  input  logic              margin_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic [DATA_W-1:0] mrg_i,
  input  logic [DATA_W-1:0] force_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] sensed;
  logic [DATA_W-1:0] rdata_q;

  // low threshold sees partly crystallised cells as set
  assign sensed = (margin_i ? (val_i | mrg_i) : val_i) | force_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_op_i) rdata_q <= sensed;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/pcm_fault_mem.sv
module pcm_fault_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic              margin_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [2:0]        fault_sel_i,
  input  logic [ADDR_W-1:0] victim_i,
  input  logic [ADDR_W-1:0] aggressor_i
);
  logic              wr_op;
  logic              rd_op;
  logic              vic_upd;
  logic [DATA_W-1:0] vic_nval;
  logic [DATA_W-1:0] vic_nmrg;
  logic [DATA_W-1:0] vic_val;
  logic [DATA_W-1:0] vic_mrg;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rd_mrg;
  logic [DATA_W-1:0] rd_force;
  logic [DATA_W-1:0] armed;

  assign wr_op = we_i;
  assign rd_op = re_i && !we_i;

  pcm_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_op),
    .addr_i     (addr_i),
    .wr_val_i   (wdata_i),
    .vic_upd_i  (vic_upd),
    .vic_addr_i (victim_i),
    .vic_nval_i (vic_nval),
    .vic_nmrg_i (vic_nmrg),
    .rd_val_o   (rd_val),
    .rd_mrg_o   (rd_mrg),
    .vic_val_o  (vic_val),
    .vic_mrg_o  (vic_mrg)
  );

  pcm_fault_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fault (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fault_sel_i (fault_sel_i),
    .victim_i    (victim_i),
    .aggressor_i (aggressor_i),
    .addr_i      (addr_i),
    .wr_op_i     (wr_op),
    .rd_op_i     (rd_op),
    .wdata_i     (wdata_i),
    .vic_val_i   (vic_val),
    .vic_mrg_i   (vic_mrg),
    .vic_upd_o   (vic_upd),
    .vic_nval_o  (vic_nval),
    .vic_nmrg_o  (vic_nmrg),
    .rd_force_o  (rd_force),
    .armed_o     (armed)
  );

  pcm_read_port #(.DATA_W(DATA_W)) u_rport (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_op_i  (rd_op),
    .margin_i (margin_i),
    .val_i    (rd_val),
    .mrg_i    (rd_mrg),
    .force_i  (rd_force),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/pcm_fault_mem_chk.sv
module pcm_fault_mem_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              re_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [2:0]        fault_sel_i,
  input logic [ADDR_W-1:0] victim_i,
  input logic [ADDR_W-1:0] aggressor_i,
  input logic [DATA_W-1:0] vic_val,
  input logic [DATA_W-1:0] vic_mrg,
  input logic [DATA_W-1:0] armed
);
  logic rd_vic;
  logic wr_vic;
  logic wr_agg;
  assign rd_vic = re_i && !we_i && (addr_i == victim_i);
  assign wr_vic = we_i && (addr_i == victim_i);
  assign wr_agg = we_i && (addr_i == aggressor_i);

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(re_i && !we_i) |=> $stable(rdata_o)); // R2

  AST_PROX_KEEPS_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_sel_i == 3'd1 && wr_agg && aggressor_i != victim_i) |=> $stable(vic_val)); // R4

  AST_FWRITE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_sel_i == 3'd4 && rd_vic) |=> (vic_val == '0)); // R7

  AST_STUCK_SET_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_sel_i == 3'd5 && rd_vic) |=> ((rdata_o & $past(armed)) == $past(armed))); // R8

  AST_STUCK_RST_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_sel_i == 3'd6 && rd_vic) |=> ((rdata_o & $past(armed)) == '0)); // R9

  AST_INCPRG_MARGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_sel_i == 3'd7 && wr_vic) |=> ((vic_val | vic_mrg) == '1)); // R10
endmodule

bind pcm_fault_mem pcm_fault_mem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .we_i        (we_i),
  .re_i        (re_i),
  .rdata_o     (rdata_o),
  .fault_sel_i (fault_sel_i),
  .victim_i    (victim_i),
  .aggressor_i (aggressor_i),
  .vic_val     (vic_val),
  .vic_mrg     (vic_mrg),
  .armed       (armed)
);

// File: tb/pcm_fault_mem_tb.sv
`timescale 1ns/1ps
module pcm_fault_mem_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] addr = '0;
  logic       we = 1'b0;
  logic [3:0] wdata = '0;
  logic       re = 1'b0;
  logic       margin = 1'b0;
  logic [3:0] rdata;
  logic [2:0] fsel = '0;
  logic [3:0] victim = '0;
  logic [3:0] aggr = '0;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pcm_fault_mem #(.ADDR_W(4), .DATA_W(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .margin_i(margin), .rdata_o(rdata), .fault_sel_i(fsel),
    .victim_i(victim), .aggressor_i(aggr)
  );

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [3:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, input logic m, input logic [3:0] exp, input string tag);
    addr = a; margin = m; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    check(rdata, exp, tag);
  endtask

  task automatic do_rst(input logic [2:0] f, input logic [3:0] v, input logic [3:0] g);
    rst_ni = 1'b0; fsel = f; victim = v; aggr = g;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic other_word(input logic [3:0] a, input logic [3:0] d, input string tag);
    do_wr(a, d);
    do_rd(a, 1'b0, d, tag);
    do_rd(a, 1'b1, d, tag);
    do_rd(a, 1'b0, d, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [3:0] arm;
    logic [3:0] d;
    logic [3:0] vv [4];
    logic [3:0] gg [4];
    logic       nb [4];
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(rdata, 4'h0, "R1 rdata after reset");
    for (int a = 0; a < 16; a++) begin
      do_rd(4'(a), 1'b0, 4'h0, "R1 normal read after reset");
      do_rd(4'(a), 1'b1, 4'h0, "R1 margin read after reset");
    end

    // fault-free sweep
    for (int a = 0; a < 16; a++) do_wr(4'(a), 4'((a * 5 + 3) & 15));
    for (int a = 0; a < 16; a++) begin
      do_rd(4'(a), 1'b0, 4'((a * 5 + 3) & 15), "R2 normal read");
      do_rd(4'(a), 1'b1, 4'((a * 5 + 3) & 15), "R2 margin read");
    end
    do_rd(4'd2, 1'b0, 4'hD, "R2 read before collision");
    addr = 4'd9; wdata = 4'h6; we = 1'b1; re = 1'b1;
    @(negedge clk);
    we = 1'b0; re = 1'b0;
    check(rdata, 4'hD, "R2 write wins, rdata held");
    @(negedge clk);
    check(rdata, 4'hD, "R2 idle hold");
    do_rd(4'd9, 1'b0, 4'h6, "R2 collided write landed");

    // proximity disturb
    vv[0] = 4'd5;  gg[0] = 4'd6; nb[0] = 1'b1;
    vv[1] = 4'd5;  gg[1] = 4'd4; nb[1] = 1'b1;
    vv[2] = 4'd5;  gg[2] = 4'd7; nb[2] = 1'b0;
    vv[3] = 4'd15; gg[3] = 4'd0; nb[3] = 1'b0;
    for (int c = 0; c < 4; c++) begin
      do_rst(3'd1, vv[c], gg[c]);
      for (int vd = 0; vd < 16; vd++) begin
        for (int ad = 0; ad < 16; ad++) begin
          do_wr(vv[c], 4'(vd));
          do_wr(gg[c], 4'(ad));
          do_rd(vv[c], 1'b0, 4'(vd), "R4 victim normal read");
          do_rd(vv[c], 1'b1,
                nb[c] ? 4'(vd | (~vd & ~ad & 15)) : 4'(vd),
                nb[c] ? "R4 margin read after neighbour write" : "R4 non-neighbour no effect");
        end
      end
      do_rd(gg[c], 1'b1, 4'hF, "R3 aggressor word unaffected");
    end

    // read recovery
    do_rst(3'd2, 4'd3, 4'd0);
    for (int od = 0; od < 16; od++) begin
      for (int nd = 0; nd < 16; nd++) begin
        do_wr(4'd3, 4'(od));
        do_wr(4'd3, 4'(nd));
        do_rd(4'd3, 1'b0, 4'(nd | (od & ~nd)), "R5 read right after write");
        do_rd(4'd3, 1'b0, 4'(nd), "R5 second read");
        do_wr(4'd3, 4'(od));
        do_wr(4'd3, 4'(nd));
        do_rd(4'd8, 1'b0, 4'h0, "R3 other word under read recovery");
        do_rd(4'd3, 1'b0, 4'(nd), "R5 read after intervening op");
      end
    end

    // read disturb
    do_rst(3'd3, 4'd10, 4'd0);
    for (int dd = 0; dd < 16; dd++) begin
      do_wr(4'd10, 4'(dd));
      do_rd(4'd10, 1'b0, 4'(dd), "R6 first read");
      do_rd(4'd10, 1'b1, 4'hF, "R6 margin after read");
      do_rd(4'd10, 1'b0, 4'(dd), "R6 normal after read");
    end
    other_word(4'd11, 4'h5, "R3 other word under read disturb");

    // false write
    do_rst(3'd4, 4'd0, 4'd0);
    for (int dd = 0; dd < 16; dd++) begin
      do_wr(4'd0, 4'(dd));
      do_rd(4'd0, 1'b0, 4'(dd), "R7 first read");
      do_rd(4'd0, 1'b0, 4'h0, "R7 second read");
    end
    other_word(4'd1, 4'hA, "R3 other word under false write");

    // stuck set / stuck reset
    for (int f = 5; f <= 6; f++) begin
      do_rst(3'(f), 4'd7, 4'd0);
      arm = 4'h0;
      do_wr(4'd7, 4'hF);
      do_rd(4'd7, 1'b0, 4'hF, f == 5 ? "R8 before arming" : "R9 before arming");
      for (int k = 0; k < 16; k++) begin
        d = 4'(((k * 7) ^ 9) & 15);
        if (k % 4 == 3) d = 4'hF;
        do_wr(4'd7, d);
        arm = arm | ~d;
        do_rd(4'd7, 1'b0, f == 5 ? (d | arm) : (d & ~arm), f == 5 ? "R8 stuck set" : "R9 stuck reset");
        do_rd(4'd7, 1'b1, f == 5 ? (d | arm) : (d & ~arm), f == 5 ? "R8 margin" : "R9 margin");
      end
      other_word(4'd6, 4'h3, "R3 other word under stuck fault");
    end

    // incomplete program
    do_rst(3'd7, 4'd12, 4'd0);
    for (int dd = 0; dd < 16; dd++) begin
      do_wr(4'd12, 4'(dd));
      do_rd(4'd12, 1'b0, 4'(dd), "R10 normal read");
      do_rd(4'd12, 1'b1, 4'hF, "R10 margin read");
    end
    other_word(4'd13, 4'h0, "R3 other word under incomplete program");

    // normal write clears marginal flag
    do_wr(4'd12, 4'h2);
    fsel = 3'd0;
    do_rd(4'd12, 1'b1, 4'hF, "R11 marginal before rewrite");
    do_wr(4'd12, 4'h2);
    do_rd(4'd12, 1'b1, 4'h2, "R11 margin after normal write");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule